// File: doc/BRIEF.md
# Nine-bit SPI panel command sequencer

This block powers up a small display panel and feeds it command frames over a write-only serial link with 9-bit words. It keeps the panel reset line asserted from power-up until the supplies report good. It then waits a settling time, releases reset and waits again. After that it plays an initialisation sequence stored in an internal ROM. Each byte of a frame goes out as one 9-bit word. The top bit of that word tells the panel whether the byte is the command opening the frame or one of the parameters that follow it.

Every frame is followed by a fixed gap before the next one may start. Once the panel is initialised, single-byte requests switch the display on or put the panel to sleep. Sleep entry has its own extra settling wait. A power-down request asserts reset, waits, and then tells the system that the supplies may be switched off.

All delays are counted in microseconds. The microsecond tick is derived from a system clock frequency parameter. A busy output covers every sequence from its first action until its last delay has run out.

Top module: `pnl_cmd_seq`

## Requirements
- R1: After reset, panel_rst is 1, spi_csn is 1, spi_sclk is 1, busy is 0 and supply_off_ok is 0.
- R2: While supply_good stays low after reset, panel_rst stays 1 and no word is sent; enable and disable requests in that state send nothing.
- R3: After supply_good rises, panel_rst falls no earlier than PRE_US microseconds later.
- R4: The first word of the init sequence starts no earlier than POST_US microseconds after panel_rst falls, and chip select is never low while panel_rst is 1.
- R5: Each word is 9 bits, MSB first. Bit 8 is 0 for the first byte of a frame and 1 for each later byte, and bits 7..0 carry the byte. The default init sequence is four frames, sent in this order: {0xF2,0x02,0x03,0x1C}, {0xB3,0x0C}, {0xC0,0x01}, {0x11}. The last frame is the exit-sleep command with no parameters.
- R6: The serial clock idles high whenever chip select is high (clock polarity and phase both 1). Data changes only while the clock is low, so it is stable across each rising edge.
- R7: Between the end of one frame's last word and the start of the next frame's first word there are at least GAP_US microseconds.
- R8: busy is 1 from the start of a sequence and falls no earlier than GAP_US microseconds after the last word of the sequence ends.
- R9: An enable request in the ready state sends the single-command frame 0x29 (word 0x029) once. A further enable while already enabled sends nothing and leaves busy at 0.
- R10: A disable request while enabled sends the frame 0x10 (word 0x010). busy then stays 1 for at least GAP_US plus SLEEP_US microseconds after that word ends. A disable while not enabled sends nothing.
- R11: A power-down request in the ready state sets panel_rst to 1. supply_off_ok rises no earlier than OFF_US microseconds later and falls once supply_good goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_good | input | 1 | Panel supplies are up and stable |
| en_req | input | 1 | Request to switch the display on |
| dis_req | input | 1 | Request to put the panel to sleep |
| pdn_req | input | 1 | Request to power the panel down |
| panel_rst | output | 1 | Panel reset line, 1 = held in reset |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_csn | output | 1 | Chip select, active low for each word |
| spi_mosi | output | 1 | Serial data, MSB first |
| supply_off_ok | output | 1 | Supplies may now be removed |
| busy | output | 1 | A sequence or its trailing delay is in progress |

## Verification
The ROM pointer or the frame byte counter could go wrong inside the block. That would show within one frame as a wrong word value or a wrong command/parameter flag in the captured serial stream. A wrong delay load or a lost tick shows as a measured gap, reset-release time or busy-fall time that is too short, at the first transition that uses that delay. Enable state that has become stale shows as a repeated or missing display-on or sleep frame after the very next request. The bench decodes every word at the rising serial clock edge and checks its timing against microsecond counts it works out for itself.

// File: rtl/pnl_pkg.sv
package pnl_pkg;

   localparam int WORD_W = 9;
   localparam int ROM_AW = 4;

   localparam logic [7:0] CMD_WAKE     = 8'h11;
   localparam logic [7:0] CMD_SLEEP_IN = 8'h10;
   localparam logic [7:0] CMD_DISP_ON  = 8'h29;

   typedef enum logic [3:0] {
      ST_OFF,
      ST_PRE,
      ST_POST,
      ST_LEN,
      ST_LOAD,
      ST_SHIFT,
      ST_GAP,
      ST_READY,
      ST_SLEEP,
      ST_PDN,
      ST_DOWN
   } seq_state_t;

   function automatic int umax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // Each frame is stored as a length byte, then its bytes; length 0 ends the list.
   function automatic logic [7:0] init_rom(input logic [ROM_AW-1:0] a);
      logic [7:0] v;
      case (a)
         4'd0:    v = 8'd4;
         4'd1:    v = 8'hF2;
         4'd2:    v = 8'h02;
         4'd3:    v = 8'h03;
         4'd4:    v = 8'h1C;
         4'd5:    v = 8'd2;
         4'd6:    v = 8'hB3;
         4'd7:    v = 8'h0C;
         4'd8:    v = 8'd2;
         4'd9:    v = 8'hC0;
         4'd10:   v = 8'h01;
         4'd11:   v = 8'd1;
         4'd12:   v = CMD_WAKE;
         default: v = 8'd0;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/pnl_delay.sv
module pnl_delay #(
   parameter int US_DIV = 50,
   parameter int CNT_W  = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] us_len,
   output logic             done
);

   logic             run;
   logic [CNT_W-1:0] remain;
   logic             tick;

   if (US_DIV < 1) begin : g_bad_div
      $error("pnl_delay: US_DIV must be at least 1");
   end

   generate
      if (US_DIV == 1) begin : g_direct
         assign tick = run;
      end else begin : g_prescale
         localparam int PW = $clog2(US_DIV);
         logic [PW-1:0] pre;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          pre <= '0;
            else if (start || !run)              pre <= '0;
            else if (pre == PW'(US_DIV - 1))     pre <= '0;
            else                                 pre <= pre + 1'b1;
         end
         assign tick = run && (pre == PW'(US_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run    <= 1'b0;
         remain <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            if (us_len == '0) begin
               run  <= 1'b0;
               done <= 1'b1;
            end else begin
               run    <= 1'b1;
               remain <= us_len;
            end
         end else if (tick) begin
            remain <= remain - 1'b1;
            if (remain == CNT_W'(1)) begin
               run  <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !run);  // R3
   AST_RUN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (remain != '0));  // R7

endmodule

// File: rtl/pnl_spi9.sv
module pnl_spi9 import pnl_pkg::*; #(
   parameter int SCLK_HALF = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] word,
   output logic              sclk,
   output logic              csn,
   output logic              mosi,
   output logic              done
);

   localparam int HW    = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
   localparam int LAST  = 2 * WORD_W;
   localparam int STP_W = $clog2(LAST + 1);

   if (SCLK_HALF < 1) begin : g_bad_half
      $error("pnl_spi9: SCLK_HALF must be at least 1");
   end

   logic [WORD_W-1:0] sh;
   logic [STP_W-1:0]  step;
   logic [HW-1:0]     hc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk <= 1'b1;
         csn  <= 1'b1;
         mosi <= 1'b0;
         sh   <= '0;
         step <= '0;
         hc   <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (csn) begin
            if (start) begin
               csn  <= 1'b0;
               sh   <= word;
               mosi <= word[WORD_W-1];
               step <= '0;
               hc   <= '0;
            end
         end else if (hc == HW'(SCLK_HALF - 1)) begin
            hc   <= '0;
            step <= step + 1'b1;
            if (step == STP_W'(LAST)) begin
               csn  <= 1'b1;
               sclk <= 1'b1;
               done <= 1'b1;
            end else if (!step[0]) begin
               sclk <= 1'b0;
               if (step != '0) begin
                  mosi <= sh[WORD_W-2];
                  sh   <= {sh[WORD_W-2:0], 1'b0};
               end
            end else begin
               sclk <= 1'b1;
            end
         end else begin
            hc <= hc + 1'b1;
         end
      end
   end

   AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      csn |-> sclk);  // R6
   AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!csn && sclk && $past(sclk) && !$past(csn)) |-> $stable(mosi));  // R6

endmodule

// File: rtl/pnl_cmd_seq.sv
module pnl_cmd_seq import pnl_pkg::*; #(
   parameter int CLK_HZ    = 50_000_000,
   parameter int SCLK_HALF = 4,
   parameter int PRE_US    = 25_000,
   parameter int POST_US   = 120_000,
   parameter int GAP_US    = 300,
   parameter int SLEEP_US  = 200_000,
   parameter int OFF_US    = 120_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_good,
   input  logic en_req,
   input  logic dis_req,
   input  logic pdn_req,
   output logic panel_rst,
   output logic spi_sclk,
   output logic spi_csn,
   output logic spi_mosi,
   output logic supply_off_ok,
   output logic busy
);

   localparam int US_DIV = CLK_HZ / 1_000_000;
   localparam int MAX_US = umax(umax(umax(PRE_US, POST_US), umax(GAP_US, SLEEP_US)), OFF_US);
   localparam int CNT_W  = $clog2(MAX_US + 1);

   if (CLK_HZ < 1_000_000 || (CLK_HZ % 1_000_000) != 0) begin : g_bad_clk
      $error("pnl_cmd_seq: CLK_HZ must be a whole number of MHz");
   end

   seq_state_t        state;
   logic [ROM_AW-1:0] ptr;
   logic [7:0]        left;
   logic              first;
   logic              from_rom;
   logic              enabled;
   logic [7:0]        cmd_q;
   logic              dly_start;
   logic [CNT_W-1:0]  dly_len;
   logic              dly_done;
   logic              spi_start;
   logic [WORD_W-1:0] spi_word;
   logic              spi_done;
   logic [7:0]        rom_q;

   assign rom_q = init_rom(ptr);
   assign busy  = !(state == ST_OFF || state == ST_READY || state == ST_DOWN);

   pnl_delay #(.US_DIV(US_DIV), .CNT_W(CNT_W)) u_delay (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (dly_start),
      .us_len (dly_len),
      .done   (dly_done)
   );

   pnl_spi9 #(.SCLK_HALF(SCLK_HALF)) u_spi (
      .clk   (clk),
      .rst_n (rst_n),
      .start (spi_start),
      .word  (spi_word),
      .sclk  (spi_sclk),
      .csn   (spi_csn),
      .mosi  (spi_mosi),
      .done  (spi_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state         <= ST_OFF;
         ptr           <= '0;
         left          <= '0;
         first         <= 1'b0;
         from_rom      <= 1'b0;
         enabled       <= 1'b0;
         cmd_q         <= '0;
         dly_start     <= 1'b0;
         dly_len       <= '0;
         spi_start     <= 1'b0;
         spi_word      <= '0;
         panel_rst     <= 1'b1;
         supply_off_ok <= 1'b0;
      end else begin
         dly_start <= 1'b0;
         spi_start <= 1'b0;
         case (state)
            ST_OFF: begin
               if (supply_good) begin
                  dly_start <= 1'b1;
                  dly_len   <= CNT_W'(PRE_US);
                  state     <= ST_PRE;
               end
            end
            ST_PRE: begin
               if (dly_done) begin
                  panel_rst <= 1'b0;
                  dly_start <= 1'b1;
                  dly_len   <= CNT_W'(POST_US);
                  state     <= ST_POST;
               end
            end
            ST_POST: begin
               if (dly_done) begin
                  ptr      <= '0;
                  from_rom <= 1'b1;
                  state    <= ST_LEN;
               end
            end
            ST_LEN: begin
               if (rom_q == 8'd0) begin
                  state <= ST_READY;
               end else begin
                  left  <= rom_q;
                  ptr   <= ptr + 1'b1;
                  first <= 1'b1;
                  state <= ST_LOAD;
               end
            end
            ST_LOAD: begin
               spi_start <= 1'b1;
               spi_word  <= {~first, (from_rom ? rom_q : cmd_q)};
               if (from_rom) ptr <= ptr + 1'b1;
               left  <= left - 1'b1;
               first <= 1'b0;
               state <= ST_SHIFT;
            end
            ST_SHIFT: begin
               if (spi_done) begin
                  if (left == 8'd0) begin
                     dly_start <= 1'b1;
                     dly_len   <= CNT_W'(GAP_US);
                     state     <= ST_GAP;
                  end else begin
                     state <= ST_LOAD;
                  end
               end
            end
            ST_GAP: begin
               if (dly_done) begin
                  if (from_rom) begin
                     state <= ST_LEN;
                  end else if (cmd_q == CMD_SLEEP_IN) begin
                     dly_start <= 1'b1;
                     dly_len   <= CNT_W'(SLEEP_US);
                     state     <= ST_SLEEP;
                  end else begin
                     state <= ST_READY;
                  end
               end
            end
            ST_READY: begin
               if (pdn_req) begin
                  panel_rst <= 1'b1;
                  dly_start <= 1'b1;
                  dly_len   <= CNT_W'(OFF_US);
                  state     <= ST_PDN;
               end else if (en_req && !enabled) begin
                  enabled  <= 1'b1;
                  cmd_q    <= CMD_DISP_ON;
                  from_rom <= 1'b0;
                  left     <= 8'd1;
                  first    <= 1'b1;
                  state    <= ST_LOAD;
               end else if (dis_req && enabled) begin
                  enabled  <= 1'b0;
                  cmd_q    <= CMD_SLEEP_IN;
                  from_rom <= 1'b0;
                  left     <= 8'd1;
                  first    <= 1'b1;
                  state    <= ST_LOAD;
               end
            end
            ST_SLEEP: begin
               if (dly_done) state <= ST_READY;
            end
            ST_PDN: begin
               if (dly_done) begin
                  supply_off_ok <= 1'b1;
                  state         <= ST_DOWN;
               end
            end
            ST_DOWN: begin
               if (!supply_good) begin
                  supply_off_ok <= 1'b0;
                  enabled       <= 1'b0;
                  state         <= ST_OFF;
               end
            end
            default: state <= ST_OFF;
         endcase
      end
   end

   AST_RST_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_OFF) |-> panel_rst);  // R2
   AST_NO_WORD_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      !spi_csn |-> !panel_rst);  // R4
   AST_BUSY_WHILE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      !spi_csn |-> busy);  // R8
   AST_OFF_OK_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      supply_off_ok |-> panel_rst);  // R11

endmodule

// File: tb/pnl_cmd_seq_tb.sv
module pnl_cmd_seq_tb;

   localparam int CLK_PERIOD = 10;
   localparam int CLK_HZ     = 4_000_000;
   localparam int DIV        = CLK_HZ / 1_000_000;
   localparam int HALF       = 2;
   localparam int PRE_US     = 6;
   localparam int POST_US    = 10;
   localparam int GAP_US     = 3;
   localparam int SLEEP_US   = 20;
   localparam int OFF_US     = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic supply_good = 1'b0;
   logic en_req = 1'b0;
   logic dis_req = 1'b0;
   logic pdn_req = 1'b0;
   logic panel_rst, spi_sclk, spi_csn, spi_mosi, supply_off_ok, busy;

   int cyc = 0;
   int n_chk = 0;
   int n_bad = 0;
   int mode_err = 0;
   int rst_err = 0;

   int nbits = 0;
   logic [8:0] shreg = '0;
   logic [8:0] words[$];
   int wstart[$];
   int wend[$];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc++;

   pnl_cmd_seq #(
      .CLK_HZ(CLK_HZ), .SCLK_HALF(HALF), .PRE_US(PRE_US), .POST_US(POST_US),
      .GAP_US(GAP_US), .SLEEP_US(SLEEP_US), .OFF_US(OFF_US)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .supply_good(supply_good), .en_req(en_req),
      .dis_req(dis_req), .pdn_req(pdn_req), .panel_rst(panel_rst),
      .spi_sclk(spi_sclk), .spi_csn(spi_csn), .spi_mosi(spi_mosi),
      .supply_off_ok(supply_off_ok), .busy(busy)
   );

   // serial word monitor: the panel samples at the rising clock edge
   always @(posedge spi_sclk) if (rst_n && !spi_csn) begin
      shreg = {shreg[7:0], spi_mosi};
      nbits++;
   end
   always @(negedge spi_csn) if (rst_n) begin
      nbits = 0;
      wstart.push_back(cyc);
   end
   always @(posedge spi_csn) if (rst_n) begin
      if (nbits == 9) words.push_back(shreg);
      else words.push_back(9'h1FF);
      wend.push_back(cyc);
   end

   // per-clock model of the line rules: idle level and reset/select exclusion
   always @(negedge clk) if (rst_n) begin
      if (spi_csn && !spi_sclk) mode_err++;
      if (!spi_csn && panel_rst) rst_err++;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic pulse(ref logic sig);
      @(negedge clk); sig = 1'b1;
      @(negedge clk); sig = 1'b0;
   endtask

   task automatic wait_busy_low(output int t);
      int k = 0;
      @(negedge clk);
      while (busy && k < 5000) begin @(negedge clk); k++; end
      t = cyc;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL R8 watchdog: actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
      $finish;
   end

   initial begin
      int t0, t1, tb, base;
      logic [8:0] exp_w[$];
      exp_w = '{9'h0F2, 9'h102, 9'h103, 9'h11C, 9'h0B3, 9'h10C, 9'h0C0, 9'h101, 9'h011};

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(panel_rst == 1'b1, "R1", "panel_rst after reset", panel_rst, 1);
      chk(spi_csn == 1'b1 && spi_sclk == 1'b1, "R1", "csn/sclk idle", {spi_csn, spi_sclk}, 3);
      chk(busy == 1'b0 && supply_off_ok == 1'b0, "R1", "busy/off_ok", {busy, supply_off_ok}, 0);

      pulse(en_req);
      pulse(dis_req);
      repeat (40) @(negedge clk);
      chk(panel_rst == 1'b1, "R2", "reset held without supply", panel_rst, 1);
      chk(words.size() == 0 && busy == 1'b0, "R2", "words before supply", words.size(), 0);

      @(negedge clk); supply_good = 1'b1; t0 = cyc;
      @(negedge clk); @(negedge clk);
      chk(busy == 1'b1, "R8", "busy after supply good", busy, 1);
      while (panel_rst) @(negedge clk);
      t1 = cyc;
      chk(t1 - t0 >= PRE_US*DIV, "R3", "reset release delay", t1 - t0, PRE_US*DIV);

      wait_busy_low(tb);
      chk(words.size() == exp_w.size(), "R5", "init word count", words.size(), exp_w.size());
      for (int i = 0; i < exp_w.size() && i < words.size(); i++)
         chk(words[i] == exp_w[i], "R5", $sformatf("init word %0d", i), words[i], exp_w[i]);
      if (wstart.size() > 0)
         chk(wstart[0] - t1 >= POST_US*DIV, "R4", "first word after release",
             wstart[0] - t1, POST_US*DIV);
      for (int i = 1; i < words.size(); i++)
         if (words[i][8] == 1'b0)
            chk(wstart[i] - wend[i-1] >= GAP_US*DIV, "R7", $sformatf("gap before word %0d", i),
                wstart[i] - wend[i-1], GAP_US*DIV);
      if (wend.size() > 0)
         chk(tb - wend[wend.size()-1] >= GAP_US*DIV, "R8", "busy fall after last gap",
             tb - wend[wend.size()-1], GAP_US*DIV);

      base = words.size();
      pulse(en_req);
      wait_busy_low(tb);
      chk(words.size() == base + 1, "R9", "enable word count", words.size(), base + 1);
      if (words.size() > base) begin
         chk(words[base] == 9'h029, "R9", "display-on word", words[base], 9'h029);
         chk(tb - wend[base] >= GAP_US*DIV, "R8", "busy after enable", tb - wend[base], GAP_US*DIV);
      end

      base = words.size();
      pulse(en_req);
      repeat (100) @(negedge clk);
      chk(words.size() == base && busy == 1'b0, "R9", "repeat enable ignored", words.size(), base);

      pulse(dis_req);
      wait_busy_low(tb);
      chk(words.size() == base + 1, "R10", "disable word count", words.size(), base + 1);
      if (words.size() > base) begin
         chk(words[base] == 9'h010, "R10", "sleep-in word", words[base], 9'h010);
         chk(tb - wend[base] >= (GAP_US + SLEEP_US)*DIV, "R10", "sleep settle",
             tb - wend[base], (GAP_US + SLEEP_US)*DIV);
      end

      base = words.size();
      pulse(dis_req);
      repeat (200) @(negedge clk);
      chk(words.size() == base && busy == 1'b0, "R10", "repeat disable ignored", words.size(), base);

      @(negedge clk); pdn_req = 1'b1; t0 = cyc;
      @(negedge clk); pdn_req = 1'b0;
      @(negedge clk);
      chk(panel_rst == 1'b1, "R11", "reset on power-down", panel_rst, 1);
      while (!supply_off_ok && cyc - t0 < 2000) @(negedge clk);
      chk(supply_off_ok == 1'b1 && cyc - t0 >= OFF_US*DIV, "R11", "off_ok delay", cyc - t0, OFF_US*DIV);
      supply_good = 1'b0;
      @(negedge clk); @(negedge clk);
      chk(supply_off_ok == 1'b0 && panel_rst == 1'b1, "R11", "off_ok cleared",
          {supply_off_ok, panel_rst}, 1);

      chk(mode_err == 0, "R6", "clock low while deselected", mode_err, 0);
      chk(rst_err == 0, "R4", "select while in reset", rst_err, 0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule